// File: doc/BRIEF.md
# Lockstep Mealy Machine Equivalence Checker

The block holds two small Mealy machines. Their next-state and output tables are set by parameters. It answers whether the two machines behave the same. It can do this in one of two ways.

In lockstep mode both machines start from their start states and take the same external input bit on every clock. A sticky flag records the first step on which their output bits differ, together with the zero-based index of that step.

In exhaustive mode the block builds the product machine of state pairs. It explores it breadth first from the start pair, using a visited bit vector and a work queue of pair indices. It stops with "not equivalent" on the first pair whose outputs differ for some input bit. It stops with "equivalent" once the queue drains and no unseen pair remains.

Top module: `fsm_equiv_checker`

## Requirements
- R1: While and directly after `rst` is high, `busy`, `done`, `equiv`, `mismatch` are 0 and `mismatch_cycle` is 0.
- R2: Table encoding: for state s and input bit b, the next state is `NEXT_x[(2*s+b)*SW +: SW]` and the output bit is `OUT_x[2*s+b]`. A `start` with `mode_exh`=0, sampled in the idle or done state, loads `START_A`/`START_B`. Each later clock steps both machines on `in_bit`.
- R3: `mismatch` rises after the first lockstep step whose two output bits differ. It then stays high, with `mismatch_cycle` frozen, until `rst`.
- R4: `mismatch_cycle` holds the zero-based index of that first differing step, where step 0 is the first clock after the start edge.
- R5: In lockstep mode `busy` is 1 and `done` is 0. `start` and `mode_exh` are ignored until `rst`.
- R6: A `start` with `mode_exh`=1, sampled in the idle or done state, begins a search. `busy` is 1 after that edge. A new search may be started from the done state without a reset.
- R7: If any pair reachable from the start pair has differing outputs for some input bit, the search ends with `done`=1 and `equiv`=0.
- R8: If every reachable pair agrees on both input bits, the search ends with `done`=1 and `equiv`=1. Disagreement in states that cannot be reached has no effect.
- R9: A search raises `done` no later than 3*NP+3 rising edges after the edge that samples `start`, where NP = 2^(2*SW).
- R10: Each pair enters the work queue at most once. The queue never overflows or underflows.
- R11: `done` and `busy` are never both high. `done` and `equiv` hold until the next accepted `start`. A `start` during a search is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (sampled in idle or done) |
| mode_exh | input | 1 | 1 selects exhaustive search, 0 lockstep |
| in_bit | input | 1 | Shared input bit for lockstep steps |
| busy | output | 1 | Run in progress |
| done | output | 1 | Search finished, verdict valid |
| equiv | output | 1 | Verdict: 1 equivalent, 0 not equivalent |
| mismatch | output | 1 | Sticky lockstep disagreement flag |
| mismatch_cycle | output | CW | Step index of first lockstep disagreement |

## Verification
In lockstep mode every output is registered. A disagreement on step i appears one edge after the edge that consumes bit i. The bench therefore drives each bit on a falling edge and samples at the falling edge after the sixth step, across all 64 six-bit sequences on an equivalent and a non-equivalent pairing. In exhaustive mode `busy` appears one edge after the start edge and `done` appears one edge after the deciding cycle. The bench counts rising edges from the start edge, compares that count with the R9 bound, and compares the verdict with its own breadth-first fixpoint over the parameter tables.

// File: rtl/fsmeq_pkg.sv
package fsmeq_pkg;
  typedef enum logic [2:0] {
    CTL_IDLE,
    CTL_LOCK,
    CTL_INIT,
    CTL_POP,
    CTL_EXP,
    CTL_DONE
  } ctl_state_e;
endpackage

// File: rtl/fsmeq_mealy_step.sv
module fsmeq_mealy_step #(
  parameter int NS = 8,
  parameter int SW = $clog2(NS),
  parameter logic [2*NS*SW-1:0] NEXT_TBL = '0,
  parameter logic [2*NS-1:0]    OUT_TBL  = '0
) (
  input  logic [SW-1:0] cur_state,
  input  logic          bit_in,
  output logic [SW-1:0] nxt_state,
  output logic          out_bit
);
  // Entry index is 2*state + input bit; states beyond NS self-loop with output 0
  always_comb begin
    nxt_state = cur_state;
    out_bit   = 1'b0;
    if (int'(cur_state) < NS) begin
      nxt_state = NEXT_TBL[(int'(cur_state)*2 + int'(bit_in))*SW +: SW];
      out_bit   = OUT_TBL[int'(cur_state)*2 + int'(bit_in)];
    end
  end
endmodule

// File: rtl/fsmeq_pair_queue.sv
module fsmeq_pair_queue #(
  parameter int W     = 6,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  logic [AW:0]  wr_ptr, rd_ptr;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  // Plain write port and registered read port, suitable for block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr[AW-1:0]] <= push_data;
    if (pop)  rd_data <= mem[rd_ptr[AW-1:0]];
  end

  assign empty = (wr_ptr == rd_ptr);

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> ((wr_ptr - rd_ptr) < (AW+1)'(DEPTH)));
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/fsmeq_seen_set.sv
module fsmeq_seen_set #(
  parameter int NP = 64,
  parameter int IW = $clog2(NP)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic [IW-1:0] query_idx,
  output logic          hit
);
  logic [NP-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst || clear)  seen <= '0;
    else if (set_en)   seen[set_idx] <= 1'b1;
  end

  assign hit = seen[query_idx];

  // A pair is marked once only, so it is enqueued at most once
  a_r10_mark_once: assert property (@(posedge clk) disable iff (rst)
    (set_en && !clear) |-> !seen[set_idx]);
endmodule

// File: rtl/fsm_equiv_checker.sv
module fsm_equiv_checker #(
  parameter int NS = 8,
  parameter int SW = $clog2(NS),
  parameter int CW = 16,
  parameter logic [2*NS*SW-1:0] NEXT_A = '0,
  parameter logic [2*NS-1:0]    OUT_A  = '0,
  parameter logic [2*NS*SW-1:0] NEXT_B = '0,
  parameter logic [2*NS-1:0]    OUT_B  = '0,
  parameter logic [SW-1:0]      START_A = '0,
  parameter logic [SW-1:0]      START_B = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mode_exh,
  input  logic          in_bit,
  output logic          busy,
  output logic          done,
  output logic          equiv,
  output logic          mismatch,
  output logic [CW-1:0] mismatch_cycle
);
  import fsmeq_pkg::*;

  localparam int PW    = 2*SW;
  localparam int NP    = 1 << PW;
  localparam int BOUND = 3*NP + 2;
  localparam int BW    = $clog2(BOUND + 2) + 1;

  ctl_state_e    state_q;
  logic [SW-1:0] lk_a, lk_b;
  logic [CW-1:0] lk_cnt;
  logic          exp_bit;
  logic [BW-1:0] exh_cnt;

  logic [SW-1:0] st_a, st_b, nxt_a, nxt_b;
  logic          step_bit, out_a, out_b, outs_differ;
  logic [PW-1:0] q_rd, q_wdata, pair_next;
  logic          q_push, q_pop, q_empty, run_clear;
  logic          vis_set, vis_hit;
  logic          start_ok, in_lock;

  assign in_lock   = (state_q == CTL_LOCK);
  assign start_ok  = start && ((state_q == CTL_IDLE) || (state_q == CTL_DONE));
  assign st_a      = in_lock ? lk_a : q_rd[PW-1:SW];
  assign st_b      = in_lock ? lk_b : q_rd[SW-1:0];
  assign step_bit  = in_lock ? in_bit : exp_bit;
  assign pair_next = {nxt_a, nxt_b};
  assign outs_differ = (out_a != out_b);

  fsmeq_mealy_step #(.NS(NS), .SW(SW), .NEXT_TBL(NEXT_A), .OUT_TBL(OUT_A)) step_a_i (
    .cur_state(st_a), .bit_in(step_bit), .nxt_state(nxt_a), .out_bit(out_a));

  fsmeq_mealy_step #(.NS(NS), .SW(SW), .NEXT_TBL(NEXT_B), .OUT_TBL(OUT_B)) step_b_i (
    .cur_state(st_b), .bit_in(step_bit), .nxt_state(nxt_b), .out_bit(out_b));

  // Work-queue and visited-set control
  always_comb begin
    run_clear = start_ok && mode_exh;
    q_push    = 1'b0;
    q_pop     = 1'b0;
    vis_set   = 1'b0;
    q_wdata   = pair_next;
    unique case (state_q)
      CTL_INIT: begin
        q_push  = 1'b1;
        vis_set = 1'b1;
        q_wdata = {START_A, START_B};
      end
      CTL_POP: q_pop = !q_empty;
      CTL_EXP: begin
        if (!outs_differ && !vis_hit) begin
          q_push  = 1'b1;
          vis_set = 1'b1;
        end
      end
      default: ;
    endcase
  end

  fsmeq_pair_queue #(.W(PW), .DEPTH(NP)) queue_i (
    .clk(clk), .rst(rst), .clear(run_clear),
    .push(q_push), .push_data(q_wdata), .pop(q_pop),
    .rd_data(q_rd), .empty(q_empty));

  fsmeq_seen_set #(.NP(NP)) seen_i (
    .clk(clk), .rst(rst), .clear(run_clear),
    .set_en(vis_set), .set_idx(q_wdata), .query_idx(pair_next),
    .hit(vis_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= CTL_IDLE;
      busy           <= 1'b0;
      done           <= 1'b0;
      equiv          <= 1'b0;
      mismatch       <= 1'b0;
      mismatch_cycle <= '0;
      lk_a           <= '0;
      lk_b           <= '0;
      lk_cnt         <= '0;
      exp_bit        <= 1'b0;
    end else begin
      unique case (state_q)
        CTL_IDLE, CTL_DONE: begin
          if (start) begin
            busy <= 1'b1;
            done <= 1'b0;
            if (mode_exh) begin
              state_q <= CTL_INIT;
              equiv   <= 1'b0;
            end else begin
              state_q <= CTL_LOCK;
              lk_a    <= START_A;
              lk_b    <= START_B;
              lk_cnt  <= '0;
            end
          end
        end
        CTL_LOCK: begin
          lk_a <= nxt_a;
          lk_b <= nxt_b;
          if (outs_differ && !mismatch) begin
            mismatch       <= 1'b1;
            mismatch_cycle <= lk_cnt;
          end
          if (lk_cnt != '1) lk_cnt <= lk_cnt + 1'b1;
        end
        CTL_INIT: state_q <= CTL_POP;
        CTL_POP: begin
          if (q_empty) begin
            state_q <= CTL_DONE;
            busy    <= 1'b0;
            done    <= 1'b1;
            equiv   <= 1'b1;
          end else begin
            state_q <= CTL_EXP;
            exp_bit <= 1'b0;
          end
        end
        CTL_EXP: begin
          if (outs_differ) begin
            state_q <= CTL_DONE;
            busy    <= 1'b0;
            done    <= 1'b1;
            equiv   <= 1'b0;
          end else if (exp_bit) begin
            state_q <= CTL_POP;
          end else begin
            exp_bit <= 1'b1;
          end
        end
        default: state_q <= CTL_IDLE;
      endcase
    end
  end

  // Busy-cycle counter of a search, used only by the R9 bound check
  always_ff @(posedge clk) begin
    if (rst)                  exh_cnt <= '0;
    else if (busy && !in_lock) exh_cnt <= exh_cnt + 1'b1;
    else                      exh_cnt <= '0;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!busy && !done && !mismatch && !equiv && mismatch_cycle == '0));
  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    mismatch |=> mismatch);
  a_r3_index_frozen: assert property (@(posedge clk) disable iff (rst)
    mismatch |=> $stable(mismatch_cycle));
  a_r5_lock_status: assert property (@(posedge clk) disable iff (rst)
    in_lock |-> (busy && !done));
  a_r7_disagree_stops: assert property (@(posedge clk) disable iff (rst)
    (state_q == CTL_EXP && outs_differ) |=> (done && !equiv));
  a_r9_search_bound: assert property (@(posedge clk) disable iff (rst)
    exh_cnt <= BW'(BOUND));
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));
  a_r11_verdict_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(equiv)));
endmodule

// File: tb/fsm_equiv_checker_tb_top.sv
`timescale 1ns/1ps
module fsm_equiv_checker_tb_top;
  localparam int NS = 8;
  localparam int SW = 3;
  localparam int CW = 16;
  localparam int NP = 64;
  localparam int SEQ_LEN = 6;

  // Machine A: states 0..3 reachable, state 5 differs but is unreachable
  localparam logic [47:0] NXA = {3'd7,3'd7,3'd6,3'd6,3'd5,3'd5,3'd4,3'd4,
                                 3'd2,3'd3,3'd1,3'd0,3'd2,3'd3,3'd0,3'd1};
  localparam logic [15:0] OA  = 16'b0000_1100_0101_0110;
  localparam logic [47:0] NXB = {3'd7,3'd7,3'd6,3'd6,3'd5,3'd5,3'd4,3'd4,
                                 3'd3,3'd3,3'd1,3'd0,3'd2,3'd1,3'd0,3'd1};
  localparam logic [15:0] OB_EQ = 16'b0000_0000_0001_0110;
  localparam logic [15:0] OB_NE = 16'b0000_0000_0000_0110;

  logic clk = 1'b0;
  logic rst, start, mode_exh, in_bit;
  logic e_busy, e_done, e_equiv, e_mis;
  logic n_busy, n_done, n_equiv, n_mis;
  logic [CW-1:0] e_cyc, n_cyc;

  always #2.5 clk = ~clk;

  fsm_equiv_checker #(.NS(NS), .SW(SW), .CW(CW), .NEXT_A(NXA), .OUT_A(OA),
    .NEXT_B(NXB), .OUT_B(OB_EQ), .START_A(3'd0), .START_B(3'd0)) dut_i (
    .clk(clk), .rst(rst), .start(start), .mode_exh(mode_exh), .in_bit(in_bit),
    .busy(e_busy), .done(e_done), .equiv(e_equiv), .mismatch(e_mis),
    .mismatch_cycle(e_cyc));

  fsm_equiv_checker #(.NS(NS), .SW(SW), .CW(CW), .NEXT_A(NXA), .OUT_A(OA),
    .NEXT_B(NXB), .OUT_B(OB_NE), .START_A(3'd0), .START_B(3'd0)) dut_ne_i (
    .clk(clk), .rst(rst), .start(start), .mode_exh(mode_exh), .in_bit(in_bit),
    .busy(n_busy), .done(n_done), .equiv(n_equiv), .mismatch(n_mis),
    .mismatch_cycle(n_cyc));

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run exceeded cycle limit (actual %0d expected <= 150000)", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int tnext(logic [47:0] t, int s, int b);
    return int'(t[(s*2+b)*SW +: SW]);
  endfunction

  function automatic int tout(logic [15:0] o, int s, int b);
    return int'(o[s*2+b]);
  endfunction

  // First lockstep step with differing outputs, or -1
  function automatic int lock_first(logic [15:0] ob, int seq);
    int sa = 0;
    int sb = 0;
    for (int i = 0; i < SEQ_LEN; i++) begin
      int b = (seq >> i) & 1;
      int na, nb;
      if (tout(OA, sa, b) != tout(ob, sb, b)) return i;
      na = tnext(NXA, sa, b);
      nb = tnext(NXB, sb, b);
      sa = na;
      sb = nb;
    end
    return -1;
  endfunction

  // Reachability fixpoint over state pairs
  function automatic int fix_equiv(logic [15:0] ob);
    logic [NP-1:0] reach = '0;
    reach[0] = 1'b1;
    for (int it = 0; it < NP; it++) begin
      for (int p = 0; p < NP; p++) begin
        if (reach[p]) begin
          for (int b = 0; b < 2; b++) begin
            int sa = p >> SW;
            int sb = p % NS;
            if (tout(OA, sa, b) != tout(ob, sb, b)) return 0;
            reach[tnext(NXA, sa, b)*NS + tnext(NXB, sb, b)] = 1'b1;
          end
        end
      end
    end
    return 1;
  endfunction

  task automatic do_reset();
    rst = 1'b1; start = 1'b0; mode_exh = 1'b0; in_bit = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state visible before any edge with reset low
    check("R1 busy",  e_busy, 0); check("R1 done",  e_done, 0);
    check("R1 equiv", e_equiv, 0); check("R1 mismatch", e_mis, 0);
    check("R1 cycle", e_cyc, 0);
    check("R1 busy ne", n_busy, 0); check("R1 done ne", n_done, 0);
    check("R1 mismatch ne", n_mis, 0); check("R1 cycle ne", n_cyc, 0);
  endtask

  task automatic lock_run(input int seq);
    int fe, fn;
    do_reset();
    start = 1'b1; mode_exh = 1'b0;
    @(posedge clk);
    @(negedge clk);
    // R5: stray start / mode during lockstep must change nothing
    start = seq[0]; mode_exh = seq[1];
    for (int i = 0; i < SEQ_LEN; i++) begin
      in_bit = seq[i];
      @(posedge clk);
      @(negedge clk);
    end
    fe = lock_first(OB_EQ, seq);
    fn = lock_first(OB_NE, seq);
    check("R2 R3 mismatch eq", e_mis, (fe >= 0));
    check("R2 R3 mismatch ne", n_mis, (fn >= 0));
    if (fn >= 0) check("R4 first index ne", n_cyc, fn);
    check("R5 busy in lockstep", n_busy, 1);
    check("R5 done in lockstep", n_done, 0);
    start = 1'b0; mode_exh = 1'b0;
  endtask

  task automatic exh_run(input bit poke);
    int ne_edges = 0;
    int nn_edges = 0;
    int n = 1;
    start = 1'b1; mode_exh = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check("R6 busy after start", e_busy, 1);
    check("R6 busy after start ne", n_busy, 1);
    while (n <= 400 && (ne_edges == 0 || nn_edges == 0)) begin
      start = (poke && n == 2);   // R11: start mid-search is ignored
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      n++;
      if (e_done && ne_edges == 0) ne_edges = n;
      if (n_done && nn_edges == 0) nn_edges = n;
    end
    check("R8 equivalent verdict", e_equiv, fix_equiv(OB_EQ));
    check("R7 not-equivalent verdict", n_equiv, fix_equiv(OB_NE));
    check("R9 bound eq", (ne_edges > 0 && ne_edges <= 3*NP+3), 1);
    check("R9 bound ne", (nn_edges > 0 && nn_edges <= 3*NP+3), 1);
    repeat (5) @(negedge clk);
    check("R11 done held", e_done, 1);
    check("R11 verdict held", e_equiv, 1);
    check("R11 done held ne", n_done, 1);
    check("R11 busy low", n_busy, 0);
    mode_exh = 1'b0;
  endtask

  initial begin
    do_reset();
    for (int seq = 0; seq < (1 << SEQ_LEN); seq++) lock_run(seq);
    do_reset();
    exh_run(1'b1);
    exh_run(1'b0);   // R6: restart from done without reset
    do_reset();
    exh_run(1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule